// File: doc/BRIEF.md
# Measurement Mode Sequencer

The block takes one 6-bit instruction at a time, each marked by a single-cycle valid strobe. It keeps the operating mode of a metering front end and tells a separate conversion engine when to start a single or a continuous conversion and when to run a calibration. A calibration request carries its type and a two-bit channel mask. Every accepted instruction pre-empts whatever process is running. When that happens the block raises an abort pulse in the same cycle as any new start. The engine reports back with `conv_done_i` and `cal_done_i`.

Instruction bit 5 splits the code space. A zero means a control and a one means a calibration. For a calibration, bits 4:3 give the type and bits 2:0 give the channels. Codes that name no operation set a sticky fault flag, and so do combinations that are not allowed. The host polls the fault flag together with a 3-bit mode status. This lets it see, for example, that a bad code has ended a continuous run.

The states are IDLE (the power-on active idle mode), STANDBY, SINGLE, CONT and CAL. These are the transitions:
- `IDLE/SINGLE/CONT/CAL -> SINGLE | CONT | CAL` on the matching instruction.
- `any non-standby -> STANDBY` on standby.
- `SINGLE -> IDLE` on conversion done.
- `CAL -> IDLE` on calibration done.
- `non-standby -> IDLE` on halt, wakeup, soft reset or a faulty code.
- `STANDBY -> IDLE` on wakeup or soft reset only.
- `STANDBY -> STANDBY` on every other code, with the fault flag set except for a repeated standby.

Top module: `mode_sequencer`

## Requirements
- R1: While `rst_n` is low and at the first sample after release, `mode_o` is 0 (IDLE) and `invalid_o` is 0. At that point `conv_start_o`, `cal_start_o` and `abort_o` are all 0.
- R2: Code 010100 (single conversion) moves the mode to 2 and gives a one-cycle `conv_start_o` with `conv_cont_o` low. A later `conv_done_i` returns the mode to 0.
- R3: Code 010101 (continuous conversion) moves the mode to 3, gives a one-cycle `conv_start_o`, and holds `conv_cont_o` high while the mode is 3. `conv_done_i` does not change the mode.
- R4: Code 011000 (halt) moves the mode to 0 from any non-standby mode. Code 000011 (wakeup) does the same.
- R5: A calibration code has bit 5 set. Bits 4:3 give the type: 00 is DC offset, 10 is AC offset and 11 is gain. That value appears on `cal_type_o`. Bits 2:0 give the channels: 001 is current, 010 is voltage and 110 is both. These appear on `cal_mask_o` as 01, 10 and 11, with bit 0 for current and bit 1 for voltage. The mode becomes 4 and `cal_start_o` pulses for one cycle. `cal_done_i` returns the mode to 0.
- R6: An AC offset calibration (bits 4:3 = 10) is accepted only with channel code 001. With any other channel it sets `invalid_o` and gives no `cal_start_o`.
- R7: Outside standby, the following codes set `invalid_o`, move the mode to 0 and start nothing:
  - any control code other than the six listed in R2, R3, R4, R9 and R10;
  - calibration type 01;
  - any channel code other than 001, 010 or 110.
  `invalid_o` then stays high until a soft reset.
- R8: When an instruction is accepted while the mode is 2, 3 or 4, `abort_o` pulses in the same cycle as the new mode and any new start pulse. It does not pulse when the mode was 0 or 1.
- R9: Code 000010 moves the mode to 1 (STANDBY). In standby, only wakeup (000011) and soft reset (000001) leave, both to mode 0. Any other code except 000010 sets `invalid_o` and leaves the mode at 1 with no start pulse.
- R10: Soft reset (000001) from any mode gives mode 0 and clears `invalid_o` at the next sample, with `cal_type_o` and `cal_mask_o` cleared to 0.
- R11: Every output reacts at the clock edge that samples the strobe. An instruction outranks a done input arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction strobe, one cycle per instruction |
| instr_code_i | input | 6 | Instruction code |
| conv_done_i | input | 1 | Engine finished a single conversion |
| cal_done_i | input | 1 | Engine finished a calibration |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| conv_cont_o | output | 1 | High while in continuous mode |
| cal_start_o | output | 1 | One-cycle request to start a calibration |
| cal_type_o | output | 2 | Calibration type of the last accepted calibration |
| cal_mask_o | output | 2 | Channel mask, bit 0 current, bit 1 voltage |
| abort_o | output | 1 | One-cycle abort of the running process |
| mode_o | output | 3 | Mode: 0 idle, 1 standby, 2 single, 3 continuous, 4 calibration |
| invalid_o | output | 1 | Sticky fault flag for rejected instructions |

## Verification
The assertions assume that `conv_done_i` and `cal_done_i` may arrive in any mode. They also assume the strobe is sampled only on edges where reset is released. The properties therefore guard mode changes on the decoded instruction and on the current state, never on when the engine answers. The stimulus raises done inputs at random, including in modes where they must be ignored and in the same cycle as an instruction. It draws codes from a weighted mix of legal, disallowed and raw random values. This keeps the stimulus across the whole 6-bit space while still reaching every state often.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;

    localparam int CODE_W = 6;
    localparam int MODE_W = 3;
    localparam int TYPE_W = 2;
    localparam int MASK_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_STANDBY = 3'd1,
        ST_SINGLE  = 3'd2,
        ST_CONT    = 3'd3,
        ST_CAL     = 3'd4
    } mode_t;

    typedef enum logic [2:0] {
        OP_RESET,
        OP_STANDBY,
        OP_WAKE,
        OP_SINGLE,
        OP_CONT,
        OP_HALT,
        OP_CAL,
        OP_BAD
    } op_t;

    typedef struct packed {
        op_t               op;
        logic [TYPE_W-1:0] ctype;
        logic [MASK_W-1:0] mask;
    } dec_t;

endpackage

// File: rtl/mode_seq_decoder.sv
module mode_seq_decoder
    import mode_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output dec_t              dec_o
);

    logic [TYPE_W-1:0] ctype;
    logic [MASK_W-1:0] mask;
    logic              chan_ok;
    logic              type_ok;

    assign ctype = code_i[4:3];

    always_comb begin
        chan_ok = 1'b1;
        unique case (code_i[2:0])
            3'b001:  mask = 2'b01;
            3'b010:  mask = 2'b10;
            3'b110:  mask = 2'b11;
            default: begin
                mask    = 2'b00;
                chan_ok = 1'b0;
            end
        endcase
    end

    // AC offset is only meaningful on the current channel
    always_comb begin
        unique case (ctype)
            2'b00, 2'b11: type_ok = 1'b1;
            2'b10:        type_ok = (code_i[2:0] == 3'b001);
            default:      type_ok = 1'b0;
        endcase
    end

    always_comb begin
        dec_o.ctype = ctype;
        dec_o.mask  = mask;
        if (code_i[5]) begin
            dec_o.op = (chan_ok && type_ok) ? OP_CAL : OP_BAD;
        end else begin
            unique case (code_i[4:0])
                5'b00001: dec_o.op = OP_RESET;
                5'b00010: dec_o.op = OP_STANDBY;
                5'b00011: dec_o.op = OP_WAKE;
                5'b10100: dec_o.op = OP_SINGLE;
                5'b10101: dec_o.op = OP_CONT;
                5'b11000: dec_o.op = OP_HALT;
                default:  dec_o.op = OP_BAD;
            endcase
        end
    end

    always_comb begin
        if (dec_o.op == OP_CAL) begin
            assert_cal_mask_nonzero_R5: assert (dec_o.mask != 2'b00);
            assert_ac_current_only_R6: assert (dec_o.ctype != 2'b10 || dec_o.mask == 2'b01);
        end
    end

endmodule

// File: rtl/mode_seq_fsm.sv
module mode_seq_fsm
    import mode_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  dec_t              dec_i,
    input  logic              conv_done_i,
    input  logic              cal_done_i,
    output mode_t             state_o,
    output logic              conv_start_o,
    output logic              cal_start_o,
    output logic              abort_o,
    output logic              invalid_o,
    output logic [TYPE_W-1:0] cal_type_o,
    output logic [MASK_W-1:0] cal_mask_o
);

    mode_t state_q, state_d;
    logic  running;
    logic  start_conv_d, start_cal_d, set_inv_d, clr_d;

    assign running = (state_q == ST_SINGLE) || (state_q == ST_CONT) || (state_q == ST_CAL);
    assign state_o = state_q;

    always_comb begin
        state_d      = state_q;
        start_conv_d = 1'b0;
        start_cal_d  = 1'b0;
        set_inv_d    = 1'b0;
        clr_d        = 1'b0;
        if (valid_i) begin
            if (state_q == ST_STANDBY) begin
                unique case (dec_i.op)
                    OP_RESET:   begin state_d = ST_IDLE; clr_d = 1'b1; end
                    OP_WAKE:    state_d = ST_IDLE;
                    OP_STANDBY: state_d = ST_STANDBY;
                    default:    set_inv_d = 1'b1;
                endcase
            end else begin
                unique case (dec_i.op)
                    OP_RESET:   begin state_d = ST_IDLE; clr_d = 1'b1; end
                    OP_STANDBY: state_d = ST_STANDBY;
                    OP_WAKE:    state_d = ST_IDLE;
                    OP_HALT:    state_d = ST_IDLE;
                    OP_SINGLE:  begin state_d = ST_SINGLE; start_conv_d = 1'b1; end
                    OP_CONT:    begin state_d = ST_CONT;   start_conv_d = 1'b1; end
                    OP_CAL:     begin state_d = ST_CAL;    start_cal_d  = 1'b1; end
                    default:    begin state_d = ST_IDLE;   set_inv_d    = 1'b1; end
                endcase
            end
        end else if (state_q == ST_SINGLE && conv_done_i) begin
            state_d = ST_IDLE;
        end else if (state_q == ST_CAL && cal_done_i) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_start_o <= 1'b0;
            cal_start_o  <= 1'b0;
            abort_o      <= 1'b0;
            invalid_o    <= 1'b0;
            cal_type_o   <= '0;
            cal_mask_o   <= '0;
        end else begin
            conv_start_o <= start_conv_d;
            cal_start_o  <= start_cal_d;
            abort_o      <= valid_i && running;
            if (clr_d)          invalid_o <= 1'b0;
            else if (set_inv_d) invalid_o <= 1'b1;
            if (clr_d) begin
                cal_type_o <= '0;
                cal_mask_o <= '0;
            end else if (start_cal_d) begin
                cal_type_o <= dec_i.ctype;
                cal_mask_o <= dec_i.mask;
            end
        end
    end

    assert_starts_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start_o && cal_start_o));
    assert_preempt_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && running) |=> abort_o);
    assert_cal_in_cal_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |-> (state_q == ST_CAL));
    assert_single_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && state_q == ST_SINGLE && conv_done_i) |=> (state_q == ST_IDLE));
    assert_cont_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && state_q == ST_CONT) |=> (state_q == ST_CONT));
    assert_invalid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_o && !(valid_i && dec_i.op == OP_RESET)) |=> invalid_o);
    assert_standby_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !(valid_i && (dec_i.op == OP_WAKE || dec_i.op == OP_RESET)))
        |=> (state_q == ST_STANDBY));
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dec_i.op == OP_RESET) |=> (state_q == ST_IDLE && !invalid_o));

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
    import mode_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic [CODE_W-1:0] instr_code_i,
    input  logic              conv_done_i,
    input  logic              cal_done_i,
    output logic              conv_start_o,
    output logic              conv_cont_o,
    output logic              cal_start_o,
    output logic [TYPE_W-1:0] cal_type_o,
    output logic [MASK_W-1:0] cal_mask_o,
    output logic              abort_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              invalid_o
);

    dec_t  dec;
    mode_t state;

    mode_seq_decoder u_dec (
        .code_i (instr_code_i),
        .dec_o  (dec)
    );

    mode_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (instr_valid_i),
        .dec_i        (dec),
        .conv_done_i  (conv_done_i),
        .cal_done_i   (cal_done_i),
        .state_o      (state),
        .conv_start_o (conv_start_o),
        .cal_start_o  (cal_start_o),
        .abort_o      (abort_o),
        .invalid_o    (invalid_o),
        .cal_type_o   (cal_type_o),
        .cal_mask_o   (cal_mask_o)
    );

    assign mode_o      = state;
    assign conv_cont_o = (state == ST_CONT);

    assert_cont_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (mode_o == 3'd2 || mode_o == 3'd3));

endmodule

// File: tb/mode_sequencer_tb.sv
module mode_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    localparam logic [2:0] M_IDLE = 3'd0, M_STBY = 3'd1, M_SING = 3'd2, M_CONT = 3'd3, M_CAL = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v = 1'b0;
    logic [5:0] code = 6'd0;
    logic       cdone = 1'b0, kdone = 1'b0;
    logic       conv_start, conv_cont, cal_start, abort_w, invalid_w;
    logic [1:0] ctype, cmask;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [2:0] m_mode;
    logic       m_inv, m_cs, m_ks, m_ab;
    logic [1:0] m_type, m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(v), .instr_code_i(code),
        .conv_done_i(cdone), .cal_done_i(kdone),
        .conv_start_o(conv_start), .conv_cont_o(conv_cont), .cal_start_o(cal_start),
        .cal_type_o(ctype), .cal_mask_o(cmask), .abort_o(abort_w),
        .mode_o(mode), .invalid_o(invalid_w)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // kind: 0 reset,1 standby,2 wake,3 single,4 cont,5 halt,6 cal,7 bad
    function automatic int classify(input logic [5:0] c, output logic [1:0] t, output logic [1:0] m);
        t = c[4:3];
        m = 2'b00;
        if (!c[5]) begin
            case (c)
                6'b000001: return 0;
                6'b000010: return 1;
                6'b000011: return 2;
                6'b010100: return 3;
                6'b010101: return 4;
                6'b011000: return 5;
                default:   return 7;
            endcase
        end
        case (c[2:0])
            3'b001: m = 2'b01;
            3'b010: m = 2'b10;
            3'b110: m = 2'b11;
            default: return 7;
        endcase
        if (t == 2'b01) return 7;
        if (t == 2'b10 && m != 2'b01) return 7;
        return 6;
    endfunction

    task automatic model();
        logic [1:0] t, m;
        int k;
        bit run;
        run  = (m_mode == M_SING || m_mode == M_CONT || m_mode == M_CAL);
        m_cs = 0; m_ks = 0; m_ab = 0;
        if (v) begin
            k = classify(code, t, m);
            m_ab = run;
            if (m_mode == M_STBY) begin
                if (k == 0) begin m_mode = M_IDLE; m_inv = 0; m_type = 0; m_mask = 0; end
                else if (k == 2) m_mode = M_IDLE;
                else if (k != 1) m_inv = 1;
            end else begin
                case (k)
                    0: begin m_mode = M_IDLE; m_inv = 0; m_type = 0; m_mask = 0; end
                    1: m_mode = M_STBY;
                    2, 5: m_mode = M_IDLE;
                    3: begin m_mode = M_SING; m_cs = 1; end
                    4: begin m_mode = M_CONT; m_cs = 1; end
                    6: begin m_mode = M_CAL; m_ks = 1; m_type = t; m_mask = m; end
                    default: begin m_mode = M_IDLE; m_inv = 1; end
                endcase
            end
        end else if (m_mode == M_SING && cdone) m_mode = M_IDLE;
        else if (m_mode == M_CAL && kdone) m_mode = M_IDLE;
    endtask

    task automatic compare(input string tag);
        check(tag, "mode", mode, m_mode);
        check(tag, "invalid", invalid_w, m_inv);
        check(tag, "conv_start", conv_start, m_cs);
        check(tag, "cal_start", cal_start, m_ks);
        check(tag, "abort", abort_w, m_ab);
        check(tag, "cont", conv_cont, m_mode == M_CONT);
        check(tag, "cal_type", ctype, m_type);
        check(tag, "cal_mask", cmask, m_mask);
    endtask

    // drive at negedge, model, sample at following negedge
    task automatic step(input string tag, input logic iv, input logic [5:0] c,
                        input logic cd, input logic kd);
        v = iv; code = c; cdone = cd; kdone = kd;
        model();
        @(posedge clk);
        @(negedge clk);
        v = 0; cdone = 0; kdone = 0;
        compare(tag);
    endtask

    function automatic logic [5:0] pick_code();
        case ($urandom % 20)
            0: return 6'b000001;
            1, 2: return 6'b000010;
            3, 4: return 6'b000011;
            5, 6: return 6'b010100;
            7, 8: return 6'b010101;
            9: return 6'b011000;
            10: return 6'b100001;
            11: return 6'b100010;
            12: return 6'b111110;
            13: return 6'b110001;
            14: return 6'b110010;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4021));
        m_mode = M_IDLE; m_inv = 0; m_cs = 0; m_ks = 0; m_ab = 0; m_type = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        step("R2", 1, 6'b010100, 0, 0);
        step("R2", 0, 6'b0, 0, 1);            // cal done ignored in single
        step("R2", 0, 6'b0, 1, 0);            // back to idle
        step("R3", 1, 6'b010101, 0, 0);
        step("R3", 0, 6'b0, 1, 0);            // done ignored in continuous
        step("R4", 1, 6'b011000, 0, 0);       // halt with abort
        step("R5", 1, 6'b100001, 0, 0);       // DC offset, current
        step("R8", 1, 6'b111110, 0, 0);       // gain both, preempts cal
        step("R5", 0, 6'b0, 0, 1);
        step("R5", 1, 6'b110001, 0, 0);       // AC offset current
        step("R4", 1, 6'b000011, 0, 0);       // wake while running
        step("R6", 1, 6'b110010, 0, 0);       // AC voltage rejected
        step("R7", 1, 6'b001111, 0, 0);       // undefined control
        step("R10", 1, 6'b000001, 0, 0);
        step("R11", 1, 6'b010100, 1, 0);      // instruction beats done
        step("R8", 1, 6'b010101, 1, 0);       // preempt single
        step("R9", 1, 6'b000010, 0, 0);       // standby from continuous
        step("R9", 1, 6'b010100, 0, 0);       // blocked
        step("R9", 1, 6'b100001, 0, 0);       // blocked cal
        step("R9", 1, 6'b000011, 0, 0);       // wake
        step("R7", 1, 6'b101001, 0, 0);       // cal type 01
        step("R9", 1, 6'b000010, 0, 0);
        step("R10", 1, 6'b000001, 0, 0);      // soft reset leaves standby

        for (int i = 0; i < N_RANDOM; i++) begin
            logic iv;
            iv = ($urandom % 3) == 0;
            step("R11", iv, pick_code(), ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule